// File: doc/BRIEF.md
# Per-Port Broadcast Storm Suppressor

This block sits beside the ports of a line card and limits how much broadcast traffic each port may push onto the shared switching bus. For every port it keeps a running total of broadcast data words seen in the current time window. When a new broadcast packet begins on a port whose total has already reached the programmed limit, the whole packet is marked for removal. Each port is metered on its own, and one shared window timer clears every port's total at the end of each window, which lets forwarding resume.

The limit and the window length are set by the control processor through plain configuration inputs. Suppression runs only when the card is strapped as a line card (subordinate arbiter). With that strap low, nothing is dropped and the meters and timer stay cleared. Each port also keeps a saturating count of the packets it has dropped, which software can read.

Top module: `bss_storm_guard`

## Requirements
- R1: Each port has its own word total and drop decision. Traffic on one port never changes the decision or the total of another port.
- R2: A word is counted on a port in every cycle where `word_valid` is high inside a broadcast packet that was accepted at its start. The word in the start cycle is included. Totals saturate at their maximum.
- R3: When `pkt_start` is high with `pkt_is_bcast` high and the port's total is already at or above `bc_limit_words`, `drop_pulse` for that port is high for exactly the next cycle. None of that packet's words are then counted. A limit of zero drops every broadcast packet.
- R4: Packets with `pkt_is_bcast` low at their start are never counted and never dropped.
- R5: While `linecard_mode` is high, a window timer expires once every `window_cycles` cycles, counting from the first cycle the mode is high. A value of 0 or 1 means every cycle. Each expiry clears every port's total.
- R6: While `linecard_mode` is low, no packet is dropped, and all totals and the window timer are held at zero.
- R7: Each port has a drop tally of DROP_W bits, found at bits [p*DROP_W +: DROP_W] of `drop_tally` for port p. It rises by one for each dropped packet, holds at its all-ones maximum, and is cleared only by reset.
- R8: After reset, `drop_pulse` is zero, all tallies are zero, and all totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| linecard_mode | input | 1 | High enables suppression (line-card strap) |
| bc_limit_words | input | CNT_W | Broadcast word limit per window |
| window_cycles | input | TMR_W | Window length in clock cycles |
| pkt_start | input | NUM_PORTS | Per-port first-word marker |
| pkt_end | input | NUM_PORTS | Per-port last-word marker |
| word_valid | input | NUM_PORTS | Per-port data word present |
| pkt_is_bcast | input | NUM_PORTS | Per-port broadcast flag, sampled at start |
| drop_pulse | output | NUM_PORTS | One-cycle drop decision after a start |
| drop_tally | output | NUM_PORTS*DROP_W | Saturating per-port dropped-packet counts |

## Verification
The assertions assume that each port's packets are well formed: `pkt_start` arrives only between packets, every packet closes with `pkt_end`, and `word_valid` is high on its start and end cycles. They also assume that the limit and window length change only while `linecard_mode` is low. The stimulus sends packets back to back with an idle cycle between them. It reprograms the limit and window only after dropping the mode strap for at least one cycle, which also restarts the window timer at a known point, so every expected drop can be worked out from word counts alone.

// File: rtl/bss_pkg.sv
package bss_pkg;

    // Phase of the packet currently passing a port.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // between packets, or inside a non-broadcast packet
        PH_PASS = 2'd1,   // inside an accepted broadcast packet: words counted
        PH_SKIP = 2'd2    // inside a removed broadcast packet: words ignored
    } port_phase_e;

endpackage

// File: rtl/bss_window_timer.sv
module bss_window_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [TMR_W-1:0] length_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [TMR_W-1:0] tick;
    } tmr_state_t;

    tmr_state_t st_q, st_d;
    logic [TMR_W-1:0] last_tick;
    logic             expire;

    always_comb begin
        st_d      = st_q;
        last_tick = (length_i == '0) ? '0 : length_i - TMR_W'(1);
        expire    = enable_i && (st_q.tick >= last_tick);
        if (!enable_i)
            st_d.tick = '0;
        else if (expire)
            st_d.tick = '0;
        else
            st_d.tick = st_q.tick + TMR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire_o = expire;

    // R5: an expiry always restarts the window from zero
    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> st_q.tick == '0);

    // R5: between expiries the timer advances by one each cycle
    assert_steady_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !expire_o) |=> st_q.tick == $past(st_q.tick) + TMR_W'(1));

    // R6: with suppression off the timer stays at zero
    assert_idle_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> st_q.tick == '0);

endmodule

// File: rtl/bss_port_meter.sv
module bss_port_meter
    import bss_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              clear_i,
    input  logic [CNT_W-1:0]  limit_i,
    input  logic              sop_i,
    input  logic              eop_i,
    input  logic              wvalid_i,
    input  logic              bcast_i,
    output logic              drop_o,
    output logic [DROP_W-1:0] tally_o
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    typedef struct packed {
        port_phase_e       phase;
        logic [CNT_W-1:0]  words;
        logic              drop;
        logic [DROP_W-1:0] tally;
    } meter_state_t;

    meter_state_t st_q, st_d;
    logic             count_word;
    logic             over_limit;
    logic [CNT_W-1:0] base_words;

    always_comb begin
        st_d       = st_q;
        st_d.drop  = 1'b0;
        count_word = 1'b0;
        over_limit = st_q.words >= limit_i;

        if (sop_i) begin
            if (bcast_i && enable_i && over_limit) begin
                st_d.drop  = 1'b1;
                st_d.phase = PH_SKIP;
                if (st_q.tally != DROP_MAX)
                    st_d.tally = st_q.tally + DROP_W'(1);
            end else if (bcast_i) begin
                st_d.phase = PH_PASS;
                count_word = wvalid_i;
            end else begin
                st_d.phase = PH_IDLE;
            end
        end else begin
            count_word = wvalid_i && (st_q.phase == PH_PASS);
        end

        if (eop_i)
            st_d.phase = PH_IDLE;

        base_words = clear_i ? '0 : st_q.words;
        if (!enable_i)
            st_d.words = '0;
        else if (count_word && base_words != CNT_MAX)
            st_d.words = base_words + CNT_W'(1);
        else
            st_d.words = base_words;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign drop_o  = st_q.drop;
    assign tally_o = st_q.tally;

    // R3: a drop only follows an enabled broadcast start
    assert_drop_after_bcast_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> $past(sop_i && bcast_i && enable_i));

    // R3: a drop lasts a single cycle
    assert_drop_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> !drop_o || $past(sop_i));

    // R4: non-broadcast starts never produce a drop
    assert_no_drop_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_i && !bcast_i) |=> !drop_o);

    // R2: inside a window the total never falls
    assert_total_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !clear_i) |=> st_q.words >= $past(st_q.words));

    // R6: disabled meters hold zero and never drop
    assert_idle_meter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (st_q.words == '0) && !drop_o);

    // R7: a saturated tally stays saturated
    assert_tally_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tally_o == DROP_MAX) |=> (tally_o == DROP_MAX));

    // R7: the tally moves only together with a drop
    assert_tally_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tally_o != $past(tally_o)) |-> drop_o);

endmodule

// File: rtl/bss_storm_guard.sv
module bss_storm_guard #(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 16,
    parameter int TMR_W     = 16,
    parameter int DROP_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        linecard_mode,
    input  logic [CNT_W-1:0]            bc_limit_words,
    input  logic [TMR_W-1:0]            window_cycles,
    input  logic [NUM_PORTS-1:0]        pkt_start,
    input  logic [NUM_PORTS-1:0]        pkt_end,
    input  logic [NUM_PORTS-1:0]        word_valid,
    input  logic [NUM_PORTS-1:0]        pkt_is_bcast,
    output logic [NUM_PORTS-1:0]        drop_pulse,
    output logic [NUM_PORTS*DROP_W-1:0] drop_tally
);

    logic window_clear;

    bss_window_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (linecard_mode),
        .length_i (window_cycles),
        .expire_o (window_clear)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        bss_port_meter #(
            .CNT_W  (CNT_W),
            .DROP_W (DROP_W)
        ) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (linecard_mode),
            .clear_i  (window_clear),
            .limit_i  (bc_limit_words),
            .sop_i    (pkt_start[p]),
            .eop_i    (pkt_end[p]),
            .wvalid_i (word_valid[p]),
            .bcast_i  (pkt_is_bcast[p]),
            .drop_o   (drop_pulse[p]),
            .tally_o  (drop_tally[p*DROP_W +: DROP_W])
        );
    end

    // R6: with the strap low no port drops anything
    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(linecard_mode) |-> (drop_pulse == '0));

    // R1: a port drops only after its own start
    assert_drop_own_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((drop_pulse & ~$past(pkt_start)) == '0));

endmodule

// File: tb/sim_bss_storm_guard.sv
`timescale 1ns/1ps
module sim_bss_storm_guard;

    localparam int NP = 4;
    localparam int CW = 16;
    localparam int TW = 16;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              mode;
    logic [CW-1:0]     limit;
    logic [TW-1:0]     win;
    logic [NP-1:0]     sop, eop, wv, bc;
    logic [NP-1:0]     drop;
    logic [NP*DW-1:0]  tally;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bss_storm_guard #(
        .NUM_PORTS (NP), .CNT_W (CW), .TMR_W (TW), .DROP_W (DW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .linecard_mode (mode),
        .bc_limit_words (limit), .window_cycles (win),
        .pkt_start (sop), .pkt_end (eop), .word_valid (wv), .pkt_is_bcast (bc),
        .drop_pulse (drop), .drop_tally (tally)
    );

    // Vector table: port, broadcast flag, length in words, expected drop.
    // Limit 5, long window: totals build up across the table.
    localparam int NV = 10;
    localparam int V_PORT [NV] = '{0, 0, 0, 1, 0, 1, 1, 2, 2, 0};
    localparam int V_BC   [NV] = '{1, 1, 1, 1, 0, 1, 1, 0, 1, 1};
    localparam int V_LEN  [NV] = '{3, 2, 4, 4, 6, 1, 1, 9, 4, 1};
    localparam int V_EXP  [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 1};

    task automatic check(input string req, input int actual, input int expected);
        n_run++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic send(input int p, input bit isbc, input int len, output bit got);
        got = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 1) got = drop[p];
            sop = '0; eop = '0; wv = '0; bc = '0;
            sop[p] = (i == 0);
            eop[p] = (i == len - 1);
            wv[p]  = 1'b1;
            bc[p]  = isbc;
        end
        @(negedge clk);
        if (len == 1) got = drop[p];
        sop = '0; eop = '0; wv = '0; bc = '0;
    endtask

    task automatic restart(input int new_limit, input int new_win);
        @(negedge clk);
        mode  = 1'b0;
        limit = CW'(new_limit);
        win   = TW'(new_win);
        @(negedge clk);
        mode  = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit got;
        rst_n = 1'b0; mode = 1'b0; limit = '0; win = '0;
        sop = '0; eop = '0; wv = '0; bc = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 drop_pulse", int'(drop), 0);
        check("R8 drop_tally", (tally == '0) ? 0 : 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 drop after release", int'(drop), 0);

        // R1 R2 R3 R4: table walk with limit 5 and a long window
        restart(5, 5000);
        for (int v = 0; v < NV; v++) begin
            send(V_PORT[v], V_BC[v] != 0, V_LEN[v], got);
            check($sformatf("R3/R1/R2/R4 vector %0d", v), int'(got), V_EXP[v]);
        end
        // R7 R1: per-port tallies at [p*DW +: DW]
        check("R7 tally port0", int'(tally[0*DW +: DW]), 2);
        check("R7 tally port1", int'(tally[1*DW +: DW]), 1);
        check("R1 tally port2", int'(tally[2*DW +: DW]), 0);
        check("R1 tally port3", int'(tally[3*DW +: DW]), 0);

        // R5: window expiry clears totals
        restart(2, 20);
        send(3, 1'b1, 3, got);
        check("R5 fill before expiry", int'(got), 0);
        send(3, 1'b1, 1, got);
        check("R5 drop inside window", int'(got), 1);
        repeat (25) @(negedge clk);
        send(3, 1'b1, 1, got);
        check("R5 pass after expiry", int'(got), 0);
        check("R7 tally port3 after window", int'(tally[3*DW +: DW]), 1);

        // R6: strap low, limit zero: nothing dropped, tallies kept
        @(negedge clk);
        mode = 1'b0; limit = '0;
        send(2, 1'b1, 2, got);
        check("R6 no drop with mode off", int'(got), 0);
        check("R6 tally kept with mode off", int'(tally[0*DW +: DW]), 2);

        // R3: limit zero drops every broadcast packet
        restart(0, 5000);
        send(2, 1'b1, 1, got);
        check("R3 zero limit drops", int'(got), 1);
        send(2, 1'b0, 2, got);
        check("R4 plain packet with zero limit", int'(got), 0);

        // R7: saturation of the drop tally
        for (int k = 0; k < 260; k++) send(3, 1'b1, 1, got);
        check("R7 tally saturates", int'(tally[3*DW +: DW]), 255);
        check("R1 port2 tally unaffected", int'(tally[2*DW +: DW]), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule